// File: doc/BRIEF.md
# Exception Priority and Halt Resolver

This block sits beside an instruction sequencer and decides which exception vectors are processed next, one per clock, in a fixed order. At each instruction boundary the sequencer reports what happened: whether the instruction really ran, its first opcode word, decoded illegal and privileged flags, the current user or supervisor state, any trap that the instruction forced, the trace flag as it was when the instruction started, and any pending interrupt. The block turns that report into a short chain of vector numbers. Bus errors and misaligned accesses are watched on every cycle. They abort whatever is pending and take over.

Reset, bus error and address error processing form a critical window that ends when the sequencer pulses `exc_done`. A second bus or address fault inside that window latches a halt. After that the block emits nothing until reset. The vector numbers are: reset 0, bus error 2, address error 3, illegal 4, privilege violation 8, trace 9, opcode pattern 1010 gives 10 and pattern 1111 gives 11. Forced traps carry their own vector on `rpt_trap_vec`, for example 5 for a zero divisor.

Top module: `exc_priority_resolver`

## Requirements
- R1: While `rst` is high, and until the first clock edge after it falls, `vec_valid` is 1, `vec_num` is 0 and `halted` is 0. Reset processing then counts as critical until `exc_done`.
- R2: Pending vectors leave one per cycle, with `vec_valid` high. The first vector of an accepted report is shown in the cycle after the edge that accepted it. `busy` is high while vectors are pending, and a report that arrives while `busy` is high is ignored.
- R3: A report yields, in this order: the vector caused by the instruction (a fault or `rpt_trap_vec`), then trace vector 9, then `irq_vec`.
- R4: Trace vector 9 is produced only when `rpt_exec`=1, `rpt_trace`=1 and the instruction raised no illegal, unimplemented or privilege exception.
- R5: An executed opcode with bits 15:12 equal to 4'b1010 yields 10, and one equal to 4'b1111 yields 11. Both take precedence over `rpt_illegal`. Any other opcode with `rpt_illegal`=1 yields 4.
- R6: `rpt_priv`=1 with `rpt_user`=1 yields vector 8. In supervisor state (`rpt_user`=0) a privileged instruction raises nothing.
- R7: With `rpt_exec`=0 (the instruction was preempted by the interrupt), the report yields only `irq_vec`, with no trace and no instruction exception.
- R8: An access with `acc_valid`=1 and `acc_addr[0]`=1 raises address error vector 3 when `acc_fetch`=1 or `acc_size` is word (1) or long (2). A data byte access (`acc_size`=0) at an odd address raises nothing.
- R9: `bus_err` raises vector 2, and it wins over a simultaneous address error. A fault clears the pending vectors and discards a report in the same cycle. Its vector is shown in the next cycle.
- R10: A bus or address fault while critical sets `halted` on the next edge. From then on `vec_valid` stays 0 and `busy` stays 0, and reports and faults are ignored until `rst`.
- R11: After `exc_done`, a fault is handled as an ordinary fault under R9 and does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Instruction boundary report strobe |
| rpt_exec | input | 1 | Instruction actually executed |
| rpt_opcode | input | 16 | First opcode word |
| rpt_illegal | input | 1 | Decoder marked opcode illegal |
| rpt_priv | input | 1 | Instruction is privileged |
| rpt_user | input | 1 | Processor in user state |
| rpt_trap | input | 1 | Instruction forced a trap |
| rpt_trap_vec | input | 8 | Vector of the forced trap |
| rpt_trace | input | 1 | Trace flag at instruction start |
| irq_req | input | 1 | Interrupt pending at boundary |
| irq_vec | input | 8 | Interrupt vector |
| bus_err | input | 1 | External bus error |
| acc_valid | input | 1 | Bus access in progress |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_fetch | input | 1 | Access is an instruction fetch |
| exc_done | input | 1 | Current exception processing finished |
| vec_valid | output | 1 | `vec_num` is valid this cycle |
| vec_num | output | 8 | Vector number being processed |
| busy | output | 1 | Vectors pending |
| halted | output | 1 | Double fault halt latch |

## Verification
The bench builds the block with `QDEPTH`=3, the smallest queue that still holds a complete fault, trace and interrupt chain. This makes the full-queue case part of normal traffic, and a report sent into a full queue must be dropped. `ADDR_W`=16 keeps the address values short. The odd-address check looks only at bit 0, so the narrower width leaves the misaligned-access cases as they are.

// File: rtl/exc_res_pkg.sv
package exc_res_pkg;

    localparam int VEC_W    = 8;
    localparam int LIST_MAX = 3;

    localparam logic [VEC_W-1:0] VEC_RESET   = 8'd0;
    localparam logic [VEC_W-1:0] VEC_BUSERR  = 8'd2;
    localparam logic [VEC_W-1:0] VEC_ADDRERR = 8'd3;
    localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
    localparam logic [VEC_W-1:0] VEC_PRIV    = 8'd8;
    localparam logic [VEC_W-1:0] VEC_TRACE   = 8'd9;
    localparam logic [VEC_W-1:0] VEC_PAT_A   = 8'd10;
    localparam logic [VEC_W-1:0] VEC_PAT_F   = 8'd11;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                          hit;
        logic [VEC_W-1:0]              vec;
    } instr_fault_t;

    typedef struct packed {
        logic [1:0]                    cnt;
        logic [LIST_MAX-1:0][VEC_W-1:0] vec;
    } vec_list_t;

    // Instruction-level fault: unimplemented patterns, then illegal, then privilege.
    function automatic instr_fault_t classify_opcode(
        input logic [15:0] opcode,
        input logic        illegal,
        input logic        priv,
        input logic        user
    );
        instr_fault_t r;
        r.hit = 1'b1;
        r.vec = '0;
        if (opcode[15:12] == 4'b1010)      r.vec = VEC_PAT_A;
        else if (opcode[15:12] == 4'b1111) r.vec = VEC_PAT_F;
        else if (illegal)                  r.vec = VEC_ILLEGAL;
        else if (priv && user)             r.vec = VEC_PRIV;
        else                               r.hit = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/exc_list_build.sv
module exc_list_build
    import exc_res_pkg::*;
(
    input  logic             exec,
    input  logic [15:0]      opcode,
    input  logic             illegal,
    input  logic             priv,
    input  logic             user,
    input  logic             trap,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             trace,
    input  logic             irq,
    input  logic [VEC_W-1:0] irq_vec,
    output vec_list_t        list
);
    instr_fault_t fault;
    logic [1:0]   n;

    assign fault = classify_opcode(opcode, illegal, priv, user);

    always_comb begin
        list = '0;
        n    = 2'd0;
        if (exec) begin
            if (fault.hit) begin
                list.vec[n] = fault.vec;
                n = n + 2'd1;
            end else begin
                if (trap) begin
                    list.vec[n] = trap_vec;
                    n = n + 2'd1;
                end
                if (trace) begin
                    list.vec[n] = VEC_TRACE;
                    n = n + 2'd1;
                end
            end
        end
        if (irq) begin
            list.vec[n] = irq_vec;
            n = n + 2'd1;
        end
        list.cnt = n;
    end
endmodule

// File: rtl/exc_addr_check.sv
module exc_addr_check
    import exc_res_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_size_e         acc_size,
    input  logic              acc_fetch,
    output logic              addr_err
);
    logic multi_byte;

    assign multi_byte = acc_fetch || (acc_size != SZ_BYTE);
    assign addr_err   = acc_valid && acc_addr[0] && multi_byte;
endmodule

// File: rtl/exc_vec_queue.sv
module exc_vec_queue
    import exc_res_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             flush,
    input  logic [VEC_W-1:0] flush_vec,
    input  logic             load,
    input  vec_list_t        load_list,
    input  logic             pop,
    output logic             head_valid,
    output logic [VEC_W-1:0] head
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [VEC_W-1:0] ent [DEPTH];
    logic [CW-1:0]    count;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [VEC_W-1:0] load_val;
        logic [VEC_W-1:0] shift_val;
        logic [VEC_W-1:0] rst_val;

        if (i < LIST_MAX) begin : g_ld
            assign load_val = load_list.vec[i];
        end else begin : g_nold
            assign load_val = '0;
        end

        if (i < DEPTH - 1) begin : g_sh
            assign shift_val = ent[i+1];
        end else begin : g_nosh
            assign shift_val = '0;
        end

        if (i == 0) begin : g_r0
            assign rst_val = VEC_RESET;
        end else begin : g_rn
            assign rst_val = '0;
        end

        always_ff @(posedge clk) begin
            if (rst)        ent[i] <= rst_val;
            else if (clear) ent[i] <= '0;
            else if (flush) ent[i] <= (i == 0) ? flush_vec : '0;
            else if (load)  ent[i] <= load_val;
            else if (pop)   ent[i] <= shift_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        count <= CW'(1);
        else if (clear) count <= '0;
        else if (flush) count <= CW'(1);
        else if (load)  count <= CW'(load_list.cnt);
        else if (pop)   count <= count - CW'(1);
    end

    assign head_valid = (count != '0);
    assign head       = ent[0];

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2
    pop_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !clear && !flush && !load && count == CW'(1)) |=> !head_valid);
endmodule

// File: rtl/exc_priority_resolver.sv
module exc_priority_resolver
    import exc_res_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rpt_valid,
    input  logic              rpt_exec,
    input  logic [15:0]       rpt_opcode,
    input  logic              rpt_illegal,
    input  logic              rpt_priv,
    input  logic              rpt_user,
    input  logic              rpt_trap,
    input  logic [7:0]        rpt_trap_vec,
    input  logic              rpt_trace,
    input  logic              irq_req,
    input  logic [7:0]        irq_vec,
    input  logic              bus_err,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_fetch,
    input  logic              exc_done,
    output logic              vec_valid,
    output logic [7:0]        vec_num,
    output logic              busy,
    output logic              halted
);
    vec_list_t        list;
    logic             addr_err;
    logic             fault_any;
    logic             crit;
    logic             q_clear, q_flush, q_load, q_pop;
    logic [VEC_W-1:0] fault_vec;
    logic             head_valid;
    logic [VEC_W-1:0] head;

    exc_list_build i_list (
        .exec     (rpt_exec),
        .opcode   (rpt_opcode),
        .illegal  (rpt_illegal),
        .priv     (rpt_priv),
        .user     (rpt_user),
        .trap     (rpt_trap),
        .trap_vec (rpt_trap_vec),
        .trace    (rpt_trace),
        .irq      (irq_req),
        .irq_vec  (irq_vec),
        .list     (list)
    );

    exc_addr_check #(.ADDR_W(ADDR_W)) i_addr (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size_e'(acc_size)),
        .acc_fetch (acc_fetch),
        .addr_err  (addr_err)
    );

    assign fault_any = bus_err || addr_err;
    assign fault_vec = bus_err ? VEC_BUSERR : VEC_ADDRERR;

    assign q_clear = !halted && fault_any && crit;
    assign q_flush = !halted && fault_any && !crit;
    assign q_load  = !halted && !fault_any && rpt_valid && !head_valid
                     && (list.cnt != 2'd0);
    assign q_pop   = !halted && head_valid;

    exc_vec_queue #(.DEPTH(QDEPTH)) i_queue (
        .clk        (clk),
        .rst        (rst),
        .clear      (q_clear),
        .flush      (q_flush),
        .flush_vec  (fault_vec),
        .load       (q_load),
        .load_list  (list),
        .pop        (q_pop),
        .head_valid (head_valid),
        .head       (head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            crit   <= 1'b1;
            halted <= 1'b0;
        end else if (!halted) begin
            if (fault_any) begin
                crit <= 1'b1;
                if (crit) halted <= 1'b1;
            end else if (exc_done) begin
                crit <= 1'b0;
            end
        end
    end

    assign vec_valid = head_valid && !halted;
    assign vec_num   = head;
    assign busy      = head_valid && !halted;

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R10
    halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!vec_valid && !busy));

    // R10
    double_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_any && crit && !halted) |=> halted);

    // R9
    fault_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_any && !crit && !halted)
        |=> (vec_valid && vec_num == ($past(bus_err) ? VEC_BUSERR : VEC_ADDRERR)));

    // R3
    chain_head_chk: assert property (@(posedge clk) disable iff (rst)
        (q_load && rpt_exec && rpt_trap && !rpt_illegal && !rpt_priv
         && rpt_opcode[15:13] != 3'b101 && rpt_opcode[15:12] != 4'b1111)
        |=> (vec_valid && vec_num == $past(rpt_trap_vec)));
endmodule

// File: tb/test_exc_priority_resolver.sv
module test_exc_priority_resolver;
    localparam int ADDR_W = 16;
    localparam int QDEPTH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rpt_valid = 0, rpt_exec = 0, rpt_illegal = 0, rpt_priv = 0;
    logic              rpt_user = 0, rpt_trap = 0, rpt_trace = 0, irq_req = 0;
    logic [15:0]       rpt_opcode = 16'h4E71;
    logic [7:0]        rpt_trap_vec = 8'd0, irq_vec = 8'd0;
    logic              bus_err = 0, acc_valid = 0, acc_fetch = 0, exc_done = 0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [1:0]        acc_size = 2'd0;
    logic              vec_valid, busy, halted;
    logic [7:0]        vec_num;

    exc_priority_resolver #(.ADDR_W(ADDR_W), .QDEPTH(QDEPTH)) i_exc_priority_resolver (
        .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_exec(rpt_exec),
        .rpt_opcode(rpt_opcode), .rpt_illegal(rpt_illegal), .rpt_priv(rpt_priv),
        .rpt_user(rpt_user), .rpt_trap(rpt_trap), .rpt_trap_vec(rpt_trap_vec),
        .rpt_trace(rpt_trace), .irq_req(irq_req), .irq_vec(irq_vec),
        .bus_err(bus_err), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_fetch(acc_fetch), .exc_done(exc_done),
        .vec_valid(vec_valid), .vec_num(vec_num), .busy(busy), .halted(halted)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    v;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_vec(input int v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops expected vectors as the design emits them
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected vector", vec_num, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(vec_num == e.v[7:0], e.tag, vec_num, e.v);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_rpt();
        rpt_valid = 0; rpt_exec = 0; rpt_illegal = 0; rpt_priv = 0; rpt_user = 0;
        rpt_trap = 0; rpt_trace = 0; irq_req = 0; rpt_opcode = 16'h4E71;
    endtask

    task automatic report(input bit exec, input logic [15:0] op, input bit ill,
                          input bit priv, input bit user, input bit trap,
                          input int tvec, input bit trace, input bit irq, input int ivec);
        rpt_valid = 1; rpt_exec = exec; rpt_opcode = op; rpt_illegal = ill;
        rpt_priv = priv; rpt_user = user; rpt_trap = trap; rpt_trap_vec = tvec[7:0];
        rpt_trace = trace; irq_req = irq; irq_vec = ivec[7:0];
        tick();
        clear_rpt();
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 20; k++) begin
            if (exp_q.size() == 0 && !busy) break;
            tick();
        end
        tick();
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic done_pulse();
        exc_done = 1;
        tick();
        exc_done = 0;
    endtask

    task automatic access(input int addr, input int sz, input bit fetch);
        acc_valid = 1; acc_addr = addr[ADDR_W-1:0]; acc_size = sz[1:0]; acc_fetch = fetch;
        tick();
        acc_valid = 0; acc_fetch = 0;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        // R1 reset state
        check(vec_valid == 1'b1, "R1 vec_valid in reset", vec_valid, 1);
        check(vec_num == 8'd0, "R1 vec_num in reset", vec_num, 0);
        check(halted == 1'b0, "R1 halted in reset", halted, 0);
        expect_vec(0, "R1 reset vector");
        @(posedge clk); #1;
        rst = 0;
        drain("R1 reset drained");
        done_pulse();

        // R3 full chain: trap, trace, interrupt
        expect_vec(5, "R3 trap first");
        expect_vec(9, "R3 trace second");
        expect_vec(30, "R3 irq third");
        report(1, 16'h4E40, 0, 0, 0, 1, 5, 1, 1, 30);
        @(negedge clk);
        check(busy == 1'b1, "R2 busy while pending", busy, 1);
        // R2 report while busy is ignored
        tick();
        report(1, 16'h4E40, 0, 0, 0, 1, 6, 0, 0, 0);
        drain("R3 chain drained");

        // R4 trace alone
        expect_vec(9, "R4 trace only");
        report(1, 16'h4E71, 0, 0, 0, 0, 0, 1, 0, 0);
        drain("R4 drained");

        // R4 illegal suppresses trace, interrupt follows
        expect_vec(4, "R5 illegal vector");
        expect_vec(31, "R4 irq after illegal, no trace");
        report(1, 16'h4AFC, 1, 0, 0, 0, 0, 1, 1, 31);
        drain("R4 illegal drained");

        // R5 patterns, with illegal flag also set
        expect_vec(10, "R5 pattern 1010");
        report(1, 16'hA123, 1, 0, 0, 0, 0, 1, 0, 0);
        drain("R5 A drained");
        expect_vec(11, "R5 pattern 1111");
        report(1, 16'hF000, 0, 0, 0, 1, 7, 0, 0, 0);
        drain("R5 F drained");

        // R6 privilege in user state, none in supervisor
        expect_vec(8, "R6 privilege violation");
        report(1, 16'h4E72, 0, 1, 1, 0, 0, 1, 0, 0);
        drain("R6 user drained");
        expect_vec(9, "R6 supervisor priv only trace");
        report(1, 16'h4E72, 0, 1, 0, 0, 0, 1, 0, 0);
        drain("R6 supervisor drained");

        // R7 preempted instruction: only interrupt
        expect_vec(25, "R7 irq only");
        report(0, 16'hA000, 1, 1, 1, 1, 5, 1, 1, 25);
        drain("R7 drained");

        // Plain instruction: nothing
        report(1, 16'h4E71, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check(busy == 1'b0, "R2 empty report leaves idle", busy, 0);
        drain("R2 empty drained");

        // R8 odd word access
        expect_vec(3, "R8 odd word");
        access(16'h1001, 1, 0);
        drain("R8 word drained");
        done_pulse();
        // R8 odd byte data: nothing
        access(16'h1001, 0, 0);
        @(negedge clk);
        check(vec_valid == 1'b0, "R8 odd byte no error", vec_valid, 0);
        drain("R8 byte drained");
        // R8 odd fetch
        expect_vec(3, "R8 odd fetch");
        access(16'h2003, 0, 1);
        drain("R8 fetch drained");
        done_pulse();
        // R8 even long: nothing
        access(16'h2004, 2, 0);
        @(negedge clk);
        check(vec_valid == 1'b0, "R8 even long no error", vec_valid, 0);
        drain("R8 even drained");

        // R9 bus error beats address error and aborts same-cycle report
        expect_vec(2, "R9 bus error wins, report discarded");
        bus_err = 1; acc_valid = 1; acc_addr = 16'h0011; acc_size = 2'd1;
        rpt_valid = 1; rpt_exec = 1; rpt_trap = 1; rpt_trap_vec = 8'd5; rpt_trace = 1;
        tick();
        bus_err = 0; acc_valid = 0;
        clear_rpt();
        drain("R9 drained");
        done_pulse();

        // R11 after exc_done a fault is ordinary
        expect_vec(2, "R11 ordinary bus error");
        bus_err = 1; tick(); bus_err = 0;
        drain("R11 drained");
        check(halted == 1'b0, "R11 not halted", halted, 0);

        // R10 double fault without exc_done
        access(16'h3001, 2, 0);
        @(negedge clk);
        check(halted == 1'b1, "R10 halted", halted, 1);
        check(vec_valid == 1'b0, "R10 silent", vec_valid, 0);
        tick();
        report(1, 16'h4E40, 0, 0, 0, 1, 5, 1, 1, 30);
        bus_err = 1; tick(); bus_err = 0;
        done_pulse();
        @(negedge clk);
        check(halted == 1'b1, "R10 still halted", halted, 1);
        check(busy == 1'b0, "R10 ignores report", busy, 0);
        drain("R10 no vectors");

        // R1 reset restarts
        rst = 1;
        tick();
        expect_vec(0, "R1 reset after halt");
        rst = 0;
        drain("R1 restart drained");
        check(halted == 1'b0, "R1 halt cleared", halted, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule